// File: doc/BRIEF.md
# Direct-Mapped Cache with Victim Buffer

This block is a word-addressed data cache. Its main array is direct mapped: every memory block has exactly one home line, picked by an index field in the address. A small fully associative victim buffer sits between that array and the next memory level. When a valid line is pushed out of its home line, it goes into this buffer. A later conflict on the same block is then served from the buffer without any next-level traffic.

The CPU side takes one word access at a time. The CPU raises `cpu_req` and holds the address, the write flag and the write data steady until `cpu_ready` pulses. In that cycle `cpu_rdata` holds the word that was read, and `cpu_hit` tells whether the access was served without a block fetch.

The memory side moves whole blocks. A request stays up, with a stable address, until `mem_ack` pulses. On a read, the block arrives on `mem_rdata` in the acknowledge cycle. Writes follow a write-back, write-allocate policy, so dirty data reaches the next level only when the victim buffer overwrites a dirty entry.

Top module: `victim_dm_cache`

## Requirements
- R1: After reset, `cpu_ready`, `cpu_hit` and `mem_req` are low, and every line of both the main array and the victim buffer is invalid, so the first access to any address misses.
- R2: A word address is split, from the least significant end, into an OFS_W-bit word-in-block field, an IDX_W-bit line index, and a tag made of the remaining upper bits. Word w of a block is carried on bits [w*WORD_W +: WORD_W] of the memory data buses.
- R3: A main-array hit (indexed line valid, stored tag equal to the address tag) raises `cpu_ready` together with `cpu_hit` one cycle after the request is first sampled, and makes no next-level request.
- R4: When both the main array and the buffer miss, exactly one block read is issued, with block address `cpu_addr >> OFS_W`. The access then completes with `cpu_hit` low and the requested word from the fetched block.
- R5: A main miss that hits in the victim buffer (full block address match against every valid entry) completes with `cpu_hit` high two cycles after the request is sampled, with no next-level traffic and with the buffered data, including any earlier writes.
- R6: On a victim hit the two lines swap: the displaced main line takes the freed buffer entry. Two conflicting blocks accessed alternately therefore keep hitting.
- R7: A valid line evicted on a full miss enters the buffer at a rotating position. Once VDEPTH newer lines have been inserted, the oldest line is gone and misses, while newer entries still hit.
- R8: An overwritten buffer entry that is dirty is first written to the next level as one block write to its own block address, before the fill read. Overwriting a clean entry issues no write.
- R9: A write hit updates only the addressed word and issues no next-level traffic. A write miss first fills the block, then merges the word.
- R10: `cpu_ready` stays low while a next-level request is outstanding, and a request keeps its address and direction until acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | WORD_W | Write data |
| cpu_rdata | output | WORD_W | Read data, valid with `cpu_ready` |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_hit | output | 1 | Access served without a block fetch, valid with `cpu_ready` |
| mem_req | output | 1 | Next-level block request |
| mem_we | output | 1 | 1 = block write-back, 0 = block read |
| mem_addr | output | ADDR_W-OFS_W | Block address |
| mem_wdata | output | WORD_W<<OFS_W | Block write data |
| mem_ack | input | 1 | One-cycle acknowledge from the next level |
| mem_rdata | input | WORD_W<<OFS_W | Block read data, valid with `mem_ack` |

## Verification
The bench builds the cache with a 10-bit address, 4-word blocks, only 4 main lines and a 4-entry victim buffer. With only 4 lines, blocks that conflict on one index can be produced with a handful of addresses. With only 4 buffer entries, the buffer fills after a few misses, so the rotating replacement, the loss of the oldest line and the write-back of a dirty entry all happen within one short sequence. Latency, data and next-level traffic are compared for each access against a word-level shadow memory and a block memory model on the memory port.

// File: rtl/vc_pkg.sv
package vc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WBACK = 2'd1,
    ST_FILL  = 2'd2
  } vc_state_e;
endpackage

// File: rtl/vc_main_array.sv
module vc_main_array #(
  parameter int IDX_W  = 4,
  parameter int TAG_W  = 6,
  parameter int WORD_W = 32,
  parameter int OFS_W  = 2,
  localparam int LINE_W = WORD_W << OFS_W,
  localparam int LINES  = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  idx,
  output logic [TAG_W-1:0]  rd_tag,
  output logic              rd_valid,
  output logic              rd_dirty,
  output logic [LINE_W-1:0] rd_line,
  input  logic              ln_we,
  input  logic [TAG_W-1:0]  ln_tag,
  input  logic              ln_valid,
  input  logic              ln_dirty,
  input  logic [LINE_W-1:0] ln_data,
  input  logic              wd_we,
  input  logic [OFS_W-1:0]  wd_ofs,
  input  logic [WORD_W-1:0] wd_data
);
  logic [TAG_W-1:0]  tag_mem  [LINES];
  logic [LINE_W-1:0] data_mem [LINES];
  logic [LINES-1:0]  valid_q;
  logic [LINES-1:0]  dirty_q;

  assign rd_tag   = tag_mem[idx];
  assign rd_line  = data_mem[idx];
  assign rd_valid = valid_q[idx];
  assign rd_dirty = dirty_q[idx];

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (ln_we) begin
      tag_mem[idx]  <= ln_tag;
      data_mem[idx] <= ln_data;
    end else if (wd_we) begin
      data_mem[idx][wd_ofs*WORD_W +: WORD_W] <= wd_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (ln_we) begin
      valid_q[idx] <= ln_valid;
      dirty_q[idx] <= ln_dirty;
    end else if (wd_we) begin
      dirty_q[idx] <= 1'b1;
    end
  end
endmodule

// File: rtl/vc_victim_buf.sv
module vc_victim_buf #(
  parameter int DEPTH  = 8,
  parameter int BLK_W  = 10,
  parameter int LINE_W = 128,
  localparam int SEL_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BLK_W-1:0]  look_blk,
  output logic              hit,
  output logic [SEL_W-1:0]  hit_sel,
  output logic              hit_dirty,
  output logic [LINE_W-1:0] hit_data,
  output logic              ptr_valid,
  output logic              ptr_dirty,
  output logic [BLK_W-1:0]  ptr_blk,
  output logic [LINE_W-1:0] ptr_data,
  input  logic              wr_en,
  input  logic              wr_at_ptr,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic              wr_valid,
  input  logic              wr_dirty,
  input  logic [BLK_W-1:0]  wr_blk,
  input  logic [LINE_W-1:0] wr_data
);
  logic [BLK_W-1:0]  blk_q  [DEPTH];
  logic [LINE_W-1:0] data_q [DEPTH];
  logic [DEPTH-1:0]  valid_q;
  logic [DEPTH-1:0]  dirty_q;
  logic [DEPTH-1:0]  match;
  logic [SEL_W-1:0]  ptr_q;
  logic [SEL_W-1:0]  tgt;

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_cmp
      assign match[g] = valid_q[g] && (blk_q[g] == look_blk);
    end
  endgenerate

  always_comb begin
    hit_sel = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (match[i]) hit_sel = SEL_W'(i);
    end
  end

  assign hit       = |match;
  assign hit_dirty = dirty_q[hit_sel];
  assign hit_data  = data_q[hit_sel];
  assign ptr_valid = valid_q[ptr_q];
  assign ptr_dirty = dirty_q[ptr_q];
  assign ptr_blk   = blk_q[ptr_q];
  assign ptr_data  = data_q[ptr_q];
  assign tgt       = wr_at_ptr ? ptr_q : wr_sel;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      blk_q[tgt]  <= wr_blk;
      data_q[tgt] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      dirty_q <= '0;
      ptr_q   <= '0;
    end else if (wr_en) begin
      valid_q[tgt] <= wr_valid;
      dirty_q[tgt] <= wr_dirty;
      if (wr_at_ptr) begin
        if (ptr_q == SEL_W'(DEPTH - 1)) ptr_q <= '0;
        else                            ptr_q <= ptr_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/victim_dm_cache.sv
module victim_dm_cache
  import vc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int WORD_W = 32,
  parameter int OFS_W  = 2,
  parameter int IDX_W  = 4,
  parameter int VDEPTH = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        cpu_req,
  input  logic                        cpu_we,
  input  logic [ADDR_W-1:0]           cpu_addr,
  input  logic [WORD_W-1:0]           cpu_wdata,
  output logic [WORD_W-1:0]           cpu_rdata,
  output logic                        cpu_ready,
  output logic                        cpu_hit,
  output logic                        mem_req,
  output logic                        mem_we,
  output logic [ADDR_W-OFS_W-1:0]     mem_addr,
  output logic [(WORD_W<<OFS_W)-1:0]  mem_wdata,
  input  logic                        mem_ack,
  input  logic [(WORD_W<<OFS_W)-1:0]  mem_rdata
);
  localparam int BLK_W  = ADDR_W - OFS_W;
  localparam int TAG_W  = BLK_W - IDX_W;
  localparam int LINE_W = WORD_W << OFS_W;
  localparam int SEL_W  = $clog2(VDEPTH);

  vc_state_e state_q;
  logic ready_q, hit_q, missed_q;
  logic [WORD_W-1:0] rdata_q;

  logic [OFS_W-1:0] a_ofs;
  logic [IDX_W-1:0] a_idx;
  logic [TAG_W-1:0] a_tag;
  logic [BLK_W-1:0] a_blk;
  assign a_ofs = cpu_addr[OFS_W-1:0];
  assign a_idx = cpu_addr[OFS_W +: IDX_W];
  assign a_tag = cpu_addr[ADDR_W-1 -: TAG_W];
  assign a_blk = cpu_addr[ADDR_W-1:OFS_W];

  logic [TAG_W-1:0]  m_tag;
  logic              m_valid, m_dirty;
  logic [LINE_W-1:0] m_line;
  logic              ln_we, ln_valid, ln_dirty, wd_we;
  logic [TAG_W-1:0]  ln_tag;
  logic [LINE_W-1:0] ln_data;

  logic              v_hit, v_hit_dirty, v_ptr_valid, v_ptr_dirty;
  logic [SEL_W-1:0]  v_hit_sel;
  logic [LINE_W-1:0] v_hit_data, v_ptr_data;
  logic [BLK_W-1:0]  v_ptr_blk;
  logic              vw_en, vw_at_ptr;

  vc_main_array #(
    .IDX_W(IDX_W), .TAG_W(TAG_W), .WORD_W(WORD_W), .OFS_W(OFS_W)
  ) u_main (
    .clk(clk), .rst(rst), .idx(a_idx),
    .rd_tag(m_tag), .rd_valid(m_valid), .rd_dirty(m_dirty), .rd_line(m_line),
    .ln_we(ln_we), .ln_tag(ln_tag), .ln_valid(ln_valid), .ln_dirty(ln_dirty),
    .ln_data(ln_data),
    .wd_we(wd_we), .wd_ofs(a_ofs), .wd_data(cpu_wdata)
  );

  // the displaced main line is always what enters the buffer
  vc_victim_buf #(
    .DEPTH(VDEPTH), .BLK_W(BLK_W), .LINE_W(LINE_W)
  ) u_vict (
    .clk(clk), .rst(rst), .look_blk(a_blk),
    .hit(v_hit), .hit_sel(v_hit_sel), .hit_dirty(v_hit_dirty), .hit_data(v_hit_data),
    .ptr_valid(v_ptr_valid), .ptr_dirty(v_ptr_dirty), .ptr_blk(v_ptr_blk),
    .ptr_data(v_ptr_data),
    .wr_en(vw_en), .wr_at_ptr(vw_at_ptr), .wr_sel(v_hit_sel),
    .wr_valid(m_valid), .wr_dirty(m_dirty), .wr_blk({m_tag, a_idx}), .wr_data(m_line)
  );

  logic go, main_hit;
  vc_state_e state_d;
  assign go       = cpu_req && !ready_q && (state_q == ST_IDLE);
  assign main_hit = m_valid && (m_tag == a_tag);

  always_comb begin
    state_d   = state_q;
    ln_we     = 1'b0;
    ln_tag    = a_tag;
    ln_valid  = 1'b1;
    ln_dirty  = 1'b0;
    ln_data   = mem_rdata;
    wd_we     = 1'b0;
    vw_en     = 1'b0;
    vw_at_ptr = 1'b1;
    case (state_q)
      ST_IDLE: begin
        if (go) begin
          if (main_hit) begin
            wd_we = cpu_we;
          end else if (v_hit) begin
            ln_we     = 1'b1;
            ln_dirty  = v_hit_dirty;
            ln_data   = v_hit_data;
            vw_en     = 1'b1;
            vw_at_ptr = 1'b0;
          end else if (m_valid && v_ptr_valid && v_ptr_dirty) begin
            state_d = ST_WBACK;
          end else begin
            vw_en   = m_valid;
            state_d = ST_FILL;
          end
        end
      end
      ST_WBACK: begin
        if (mem_ack) begin
          vw_en   = 1'b1;
          state_d = ST_FILL;
        end
      end
      ST_FILL: begin
        if (mem_ack) begin
          ln_we   = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      ready_q  <= 1'b0;
      hit_q    <= 1'b0;
      missed_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      state_q <= state_d;
      ready_q <= 1'b0;
      hit_q   <= 1'b0;
      if (go && main_hit) begin
        ready_q  <= 1'b1;
        hit_q    <= !missed_q;
        missed_q <= 1'b0;
        rdata_q  <= m_line[a_ofs*WORD_W +: WORD_W];
      end else if (go && !v_hit) begin
        missed_q <= 1'b1;
      end
    end
  end

  assign cpu_ready = ready_q;
  assign cpu_hit   = hit_q;
  assign cpu_rdata = rdata_q;
  assign mem_req   = (state_q != ST_IDLE);
  assign mem_we    = (state_q == ST_WBACK);
  assign mem_addr  = (state_q == ST_WBACK) ? v_ptr_blk : a_blk;
  assign mem_wdata = v_ptr_data;
endmodule

// File: rtl/victim_dm_cache_chk.sv
module victim_dm_cache_chk #(
  parameter int BLK_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             cpu_ready,
  input logic             cpu_hit,
  input logic             mem_req,
  input logic             mem_we,
  input logic [BLK_W-1:0] mem_addr,
  input logic             mem_ack
);
  // R1: first cycle out of reset is quiet
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!cpu_ready && !cpu_hit && !mem_req));

  // R3: completion is a single-cycle pulse
  p_ready_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |=> !cpu_ready);

  // R3: hit flag only qualifies a completion
  p_hit_with_ready_r3: assert property (@(posedge clk) disable iff (rst)
    cpu_hit |-> cpu_ready);

  // R10: no completion while the next level is busy
  p_busy_not_ready_r10: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !cpu_ready);

  // R10: request held stable until acknowledged
  p_req_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
endmodule

bind victim_dm_cache victim_dm_cache_chk #(.BLK_W(ADDR_W - OFS_W)) u_chk (
  .clk(clk), .rst(rst), .cpu_ready(cpu_ready), .cpu_hit(cpu_hit),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_ack(mem_ack)
);

// File: tb/tb_victim_dm_cache.sv
module tb_victim_dm_cache;
  localparam int ADDR_W = 10;
  localparam int WORD_W = 32;
  localparam int OFS_W  = 2;
  localparam int IDX_W  = 2;
  localparam int VDEPTH = 4;
  localparam int BLK_W  = ADDR_W - OFS_W;
  localparam int LINE_W = WORD_W << OFS_W;
  localparam int NWORDS = 1 << ADDR_W;
  localparam int BWORDS = 1 << OFS_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cpu_req = 1'b0, cpu_we = 1'b0;
  logic [ADDR_W-1:0] cpu_addr = '0;
  logic [WORD_W-1:0] cpu_wdata = '0;
  logic [WORD_W-1:0] cpu_rdata;
  logic cpu_ready, cpu_hit, mem_req, mem_we;
  logic [BLK_W-1:0] mem_addr;
  logic [LINE_W-1:0] mem_wdata;
  logic mem_ack = 1'b0;
  logic [LINE_W-1:0] mem_rdata = '0;

  always #2.5 clk = ~clk;

  victim_dm_cache #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .OFS_W(OFS_W), .IDX_W(IDX_W), .VDEPTH(VDEPTH)
  ) dut (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
    .cpu_hit(cpu_hit), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [WORD_W-1:0] memw   [NWORDS];
  logic [WORD_W-1:0] shadow [NWORDS];
  int n_rd = 0, n_wr = 0;
  logic [BLK_W-1:0] last_rd_blk = '0;

  typedef struct { logic chk_data; logic [WORD_W-1:0] data; logic hit; string req; } exp_t;
  exp_t q[$];

  function automatic logic [WORD_W-1:0] pat(int a);
    return 32'h5A00_0000 ^ (a * 32'h0001_0003);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // next-level memory model: acknowledges 3 cycles after a request
  int lat = 0;
  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (rst) lat <= 0;
    else if (mem_req && !mem_ack) begin
      if (lat == 2) begin
        lat <= 0;
        mem_ack <= 1'b1;
        if (mem_we) begin
          for (int w = 0; w < BWORDS; w++)
            memw[{mem_addr, OFS_W'(w)}] = mem_wdata[w*WORD_W +: WORD_W];
          n_wr++;
        end else begin
          for (int w = 0; w < BWORDS; w++)
            mem_rdata[w*WORD_W +: WORD_W] <= memw[{mem_addr, OFS_W'(w)}];
          last_rd_blk = mem_addr;
          n_rd++;
        end
      end else lat <= lat + 1;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && cpu_ready) begin
      if (q.size() == 0) check(1'b0, "R3", "unexpected completion", 1, 0);
      else begin
        exp_t e;
        e = q.pop_front();
        check(cpu_hit == e.hit, e.req, "hit flag", cpu_hit, e.hit);
        if (e.chk_data) check(cpu_rdata == e.data, e.req, "read data", cpu_rdata, e.data);
      end
    end
  end

  // exp_cyc: 0 = miss (must exceed 2), else exact
  task automatic access(input bit we, input int addr, input logic [WORD_W-1:0] wd,
                        input bit exp_hit, input int exp_cyc, input int exp_rd,
                        input int exp_wr, input string req);
    exp_t e;
    int rd0, wr0, cyc;
    rd0 = n_rd; wr0 = n_wr;
    e.chk_data = !we; e.data = shadow[addr]; e.hit = exp_hit; e.req = req;
    q.push_back(e);
    if (we) shadow[addr] = wd;
    cpu_req = 1'b1; cpu_we = we; cpu_addr = ADDR_W'(addr); cpu_wdata = wd;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!cpu_ready && cyc < 300);
    cpu_req = 1'b0;
    if (exp_cyc != 0) check(cyc == exp_cyc, req, "latency", cyc, exp_cyc);
    else check(cyc > 2 && cyc < 300, req, "miss latency", cyc, 3);
    check(n_rd - rd0 == exp_rd, req, "block reads", n_rd - rd0, exp_rd);
    check(n_wr - wr0 == exp_wr, req, "block writes", n_wr - wr0, exp_wr);
    @(negedge clk);
  endtask

  function automatic int ad(int tag, int idx, int ofs);
    return (tag << (IDX_W + OFS_W)) | (idx << OFS_W) | ofs;
  endfunction

  initial begin
    #1_000_000;
    check(1'b0, "R10", "watchdog expired", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int a = 0; a < NWORDS; a++) begin
      memw[a] = pat(a);
      shadow[a] = pat(a);
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: quiet after reset
    check(!cpu_ready && !cpu_hit && !mem_req, "R1", "outputs after reset",
          {cpu_ready, cpu_hit, mem_req}, 0);

    // R1 R4: first access misses and fetches its block
    access(0, ad(0,1,0), '0, 0, 0, 1, 0, "R4");
    check(last_rd_blk == BLK_W'(ad(0,1,0) >> OFS_W), "R4", "fill block address",
          last_rd_blk, ad(0,1,0) >> OFS_W);
    // R2 R3: other words of the same block hit
    access(0, ad(0,1,3), '0, 1, 1, 0, 0, "R2");
    access(0, ad(0,1,1), '0, 1, 1, 0, 0, "R3");
    // R9: write hit, no traffic
    access(1, ad(0,1,2), 32'hDEAD_BEEF, 1, 1, 0, 0, "R9");
    access(0, ad(0,1,2), '0, 1, 1, 0, 0, "R9");
    access(0, ad(0,1,1), '0, 1, 1, 0, 0, "R9");
    // conflict: B evicts dirty A into the buffer (slot 0)
    access(0, ad(1,1,0), '0, 0, 0, 1, 0, "R4");
    // R5: victim hit returns the dirty word without traffic
    access(0, ad(0,1,2), '0, 1, 2, 0, 0, "R5");
    // R6: displaced B swapped into the buffer, hits back
    access(0, ad(1,1,3), '0, 1, 2, 0, 0, "R6");
    access(0, ad(0,1,2), '0, 1, 2, 0, 0, "R6");
    access(0, ad(1,1,1), '0, 1, 2, 0, 0, "R6");
    // R9: write miss allocates, then merges
    access(1, ad(2,3,1), 32'h1234_5678, 0, 0, 1, 0, "R9");
    access(0, ad(2,3,1), '0, 1, 1, 0, 0, "R9");
    access(0, ad(2,3,0), '0, 1, 1, 0, 0, "R2");
    // fill the buffer: slot0=A(dirty), then B, tag3, tag4
    access(0, ad(3,1,0), '0, 0, 0, 1, 0, "R7");
    access(0, ad(4,1,0), '0, 0, 0, 1, 0, "R7");
    access(0, ad(5,1,0), '0, 0, 0, 1, 0, "R7");
    // R8: overwriting dirty A writes it back first
    access(0, ad(6,1,0), '0, 0, 0, 1, 1, "R8");
    for (int w = 0; w < BWORDS; w++)
      check(memw[ad(0,1,w)] == shadow[ad(0,1,w)], "R8", "written-back word",
            memw[ad(0,1,w)], shadow[ad(0,1,w)]);
    // R7 R8: A is gone, refetched; clean B overwritten without a write
    access(0, ad(0,1,2), '0, 0, 0, 1, 0, "R8");
    access(0, ad(1,1,0), '0, 0, 0, 1, 0, "R7");
    // R7: newer entry still buffered
    access(0, ad(4,1,2), '0, 1, 2, 0, 0, "R7");
    // R2: other index untouched by the index-1 traffic
    access(0, ad(2,3,1), '0, 1, 1, 0, 0, "R2");

    repeat (4) @(negedge clk);
    check(q.size() == 0, "R3", "pending expectations", q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule